// File: doc/BRIEF.md
# Boost PFC Start-Up and Fault Supervisor

This block is the digital sequencer of a two-phase interleaved boost power-factor controller. It watches digitized samples of the bias supply, the output-voltage feedback, the voltage-amplifier output, the soft-start node and the die temperature. From these it decides whether the two gate drivers may switch and which soft-start mode the analog side applies. It also drives a request that resets the current amplifiers, an enable for the load-transient boost current, and an enable for the internal reference. The analog loops and the current sources that act on these decisions are outside the block.

Every threshold comparison passes through a two-flop synchronizer and a glitch filter of `FILT_LEN` clocks. Where a protection has hysteresis, the filtered level chooses which of the two thresholds applies. A six-state machine runs the sequence. `ST_OFF` is under-voltage or over-temperature. `ST_WAIT_EN` waits for the feedback to reach the enable level. `ST_HOLDOFF` waits until the amplifier output is at zero power. `ST_PRECHG` snaps the soft-start node quickly up to the present feedback. `ST_RAMP` is the slow ramp. `ST_RUN` is normal operation.

The transitions are as follows:
- Any state goes to `ST_OFF` on UVLO or thermal fault.
- `ST_OFF` goes to `ST_WAIT_EN` when both faults are clear.
- `ST_WAIT_EN` goes to `ST_HOLDOFF` on enable.
- `ST_HOLDOFF` goes to `ST_PRECHG` on zero power.
- `ST_PRECHG` goes to `ST_RAMP` once soft-start reaches feedback.
- `ST_RAMP` goes to `ST_RUN` once soft-start reaches regulation.
- Any of `ST_HOLDOFF`, `ST_PRECHG`, `ST_RAMP` or `ST_RUN` goes back to `ST_WAIT_EN` when enable is lost.

Top module: `pfc_startup_supervisor`

## Requirements
- R1: During and right after reset, `gate_en`, `ca_reset`, `boost_en` and `ref_en` are 0 and `ss_mode` is hold-low (2'b00).
- R2: A comparison result takes effect only after it has held for `FILT_LEN` (default 3) consecutive synchronized samples. A code sampled at edge k can first move a filtered level at edge k+FILT_LEN+1 and the registered outputs at the next edge. Shorter pulses have no effect.
- R3: Operation starts only when `vcc_code` >= 204 (10.2 V at 50 mV/LSB). Once running, the block returns to hold-low only when `vcc_code` < 184. Codes from 184 to 203 keep the current condition.
- R4: `ref_en` is 1 exactly when the filtered `vcc_code` >= 160.
- R5: The sequence leaves `ST_WAIT_EN` only when `fb_code` >= 150 (0.75 V at 5 mV/LSB). Fast precharge then begins only once the zero-power condition is present. Until then, `ss_mode` stays hold-low.
- R6: `ss_mode` is fast precharge (2'b01) until `ss_code` >= `fb_code`. After that it is slow ramp (2'b10), which stays in `ST_RUN`. `ST_RUN` is reached when `ss_code` >= 600.
- R7: `ss_code` < 120 forces `gate_en` to 0 and leaves `ss_mode` unchanged. Gating resumes when `ss_code` returns to 120 or more.
- R8: `fb_code` >= 637 sets the over-voltage condition: `gate_en` = 0 and `ca_reset` = 1, with `ss_mode` unchanged. It clears only when `fb_code` < 616.
- R9: `vao_code` < 150 sets zero power and `gate_en` = 0. Zero power clears only when `vao_code` >= 180.
- R10: `temp_code` >= 161 (°C) returns the sequence to `ST_OFF` with `ss_mode` hold-low. The fault clears when `temp_code` < 140, and recovery goes through a new soft start.
- R11: `boost_en` is 1 only in `ST_RUN` while `fb_code` < 558. It is 0 during precharge and ramp.
- R12: `gate_en` is 1 only in `ST_PRECHG`, `ST_RAMP` or `ST_RUN` with every fault clear. It falls at the edge after a filtered fault level appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_code | input | W | Bias supply sample, 50 mV/LSB |
| fb_code | input | W | Output feedback sample, 5 mV/LSB |
| vao_code | input | W | Voltage-amplifier output sample, 5 mV/LSB |
| ss_code | input | W | Soft-start node sample, 5 mV/LSB |
| temp_code | input | W | Die temperature, 1 °C/LSB |
| gate_en | output | 1 | Both gate drivers may switch |
| ca_reset | output | 1 | Pull the current-amplifier outputs low |
| ss_mode | output | 2 | 00 hold low, 01 fast precharge, 10 slow ramp |
| boost_en | output | 1 | Enable load-transient boost current |
| ref_en | output | 1 | Enable the internal reference |

## Verification
Some behaviours are checked by the assertions on every cycle:
- Hold-low mode never coexists with gating.
- A present over-voltage, external-disable or zero-power level has removed gating by the next edge.
- Under-voltage forces hold-low.
- Thermal fault lands in `ST_OFF`.
- Boost appears only in `ST_RUN`.
- A filtered level only moves toward its synchronized sample.

Other properties can only be shown by the bench's scenarios, with a reference model compared on every clock:
- The exact filter latency, and the rejection of a two-cycle pulse.
- The hysteresis bands on supply, over-voltage, zero power and temperature.
- The hand-off from fast precharge to slow ramp at the feedback level.
- The full re-sequence after a thermal fault.

// File: rtl/pfc_sup_pkg.sv
package pfc_sup_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_WAIT_EN,
        ST_HOLDOFF,
        ST_PRECHG,
        ST_RAMP,
        ST_RUN
    } sup_state_t;

    typedef enum logic [1:0] {
        SS_HOLD = 2'b00,
        SS_FAST = 2'b01,
        SS_SLOW = 2'b10
    } ss_mode_t;

    // comparator slots in the filter bank
    localparam int CI_VREF    = 0;
    localparam int CI_UVLO    = 1;
    localparam int CI_EN      = 2;
    localparam int CI_OVP     = 3;
    localparam int CI_FBHI    = 4;
    localparam int CI_VAOOK   = 5;
    localparam int CI_SSOK    = 6;
    localparam int CI_HOT     = 7;
    localparam int CI_SSREACH = 8;
    localparam int CI_SSDONE  = 9;
    localparam int NUM_CMP    = 10;

endpackage

// File: rtl/pfc_cmp_filt.sv
module pfc_cmp_filt #(
    parameter int W        = 10,
    parameter int FILT_LEN = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] code,
    input  logic [W-1:0] thr_rise,
    input  logic [W-1:0] thr_fall,
    output logic         level
);
    localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

    logic          raw;
    logic          s1_q, s2_q, out_q;
    logic [CW-1:0] cnt_q;

    // hysteresis: the present level selects which threshold applies
    always_comb begin
        raw = out_q ? (code >= thr_fall) : (code >= thr_rise);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q  <= 1'b0;
            s2_q  <= 1'b0;
            out_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            s1_q <= raw;
            s2_q <= s1_q;
            if (s2_q != out_q) begin
                if (cnt_q == CW'(FILT_LEN - 1)) begin
                    out_q <= s2_q;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign level = out_q;

    AST_FILT_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q != $past(out_q)) |-> ($past(s2_q) == out_q)); // R2

endmodule

// File: rtl/pfc_cmp_bank.sv
module pfc_cmp_bank
    import pfc_sup_pkg::*;
#(
    parameter int W        = 10,
    parameter int FILT_LEN = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CMP-1:0][W-1:0]   code_v,
    input  logic [NUM_CMP-1:0][W-1:0]   rise_v,
    input  logic [NUM_CMP-1:0][W-1:0]   fall_v,
    output logic [NUM_CMP-1:0]          lvl_v
);
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        pfc_cmp_filt #(
            .W        (W),
            .FILT_LEN (FILT_LEN)
        ) u_cmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .code     (code_v[g]),
            .thr_rise (rise_v[g]),
            .thr_fall (fall_v[g]),
            .level    (lvl_v[g])
        );
    end
endmodule

// File: rtl/pfc_sup_fsm.sv
module pfc_sup_fsm
    import pfc_sup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uvlo_ok,
    input  logic       en_ok,
    input  logic       ovp,
    input  logic       fb_hi,
    input  logic       vao_ok,
    input  logic       ss_ok,
    input  logic       hot,
    input  logic       ss_reach,
    input  logic       ss_done,
    output logic       gate_en_o,
    output logic       ca_reset_o,
    output logic [1:0] ss_mode_o,
    output logic       boost_en_o
);
    sup_state_t state_q, state_d;
    ss_mode_t   mode_d;
    logic       faults_clear;
    logic       gating_state;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!uvlo_ok || hot) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:     state_d = ST_WAIT_EN;
                ST_WAIT_EN: if (en_ok) state_d = ST_HOLDOFF;
                ST_HOLDOFF: begin
                    if (!en_ok)       state_d = ST_WAIT_EN;
                    else if (!vao_ok) state_d = ST_PRECHG;
                end
                ST_PRECHG: begin
                    if (!en_ok)        state_d = ST_WAIT_EN;
                    else if (ss_reach) state_d = ST_RAMP;
                end
                ST_RAMP: begin
                    if (!en_ok)       state_d = ST_WAIT_EN;
                    else if (ss_done) state_d = ST_RUN;
                end
                ST_RUN: if (!en_ok) state_d = ST_WAIT_EN;
                default: state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_d)
            ST_PRECHG:       mode_d = SS_FAST;
            ST_RAMP, ST_RUN: mode_d = SS_SLOW;
            default:         mode_d = SS_HOLD;
        endcase
        gating_state = (state_d == ST_PRECHG) || (state_d == ST_RAMP) || (state_d == ST_RUN);
        faults_clear = uvlo_ok && en_ok && !ovp && !hot && vao_ok && ss_ok;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_en_o  <= 1'b0;
            ca_reset_o <= 1'b0;
            ss_mode_o  <= SS_HOLD;
            boost_en_o <= 1'b0;
        end else begin
            gate_en_o  <= gating_state && faults_clear;
            ca_reset_o <= ovp;
            ss_mode_o  <= mode_d;
            boost_en_o <= (state_d == ST_RUN) && !fb_hi;
        end
    end

    AST_HOLD_NO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_mode_o == SS_HOLD) |-> !gate_en_o); // R12
    AST_OVP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        ovp |=> (!gate_en_o && ca_reset_o)); // R8
    AST_EXTDIS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_ok |=> !gate_en_o); // R7
    AST_ZP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !vao_ok |=> !gate_en_o); // R9
    AST_UVLO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !uvlo_ok |=> (ss_mode_o == SS_HOLD)); // R3
    AST_HOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        hot |=> (state_q == ST_OFF)); // R10
    AST_BOOST_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        boost_en_o |-> (state_q == ST_RUN)); // R11

endmodule

// File: rtl/pfc_startup_supervisor.sv
module pfc_startup_supervisor
    import pfc_sup_pkg::*;
#(
    parameter int W        = 10,
    parameter int FILT_LEN = 3,
    parameter int VCC_ON   = 204,
    parameter int VCC_OFF  = 184,
    parameter int VREF_ON  = 160,
    parameter int EN_TH    = 150,
    parameter int OVP_ON   = 637,
    parameter int OVP_OFF  = 616,
    parameter int BOOST_TH = 558,
    parameter int ZP_CLR   = 180,
    parameter int ZP_SET   = 150,
    parameter int SSDIS_TH = 120,
    parameter int HOT_ON   = 161,
    parameter int HOT_OFF  = 140,
    parameter int SS_REG   = 600
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] vcc_code,
    input  logic [W-1:0] fb_code,
    input  logic [W-1:0] vao_code,
    input  logic [W-1:0] ss_code,
    input  logic [W-1:0] temp_code,
    output logic         gate_en,
    output logic         ca_reset,
    output logic [1:0]   ss_mode,
    output logic         boost_en,
    output logic         ref_en
);
    logic [NUM_CMP-1:0][W-1:0] code_v, rise_v, fall_v;
    logic [NUM_CMP-1:0]        lvl_v;

    always_comb begin
        code_v[CI_VREF]    = vcc_code;  rise_v[CI_VREF]    = W'(VREF_ON);  fall_v[CI_VREF]    = W'(VREF_ON);
        code_v[CI_UVLO]    = vcc_code;  rise_v[CI_UVLO]    = W'(VCC_ON);   fall_v[CI_UVLO]    = W'(VCC_OFF);
        code_v[CI_EN]      = fb_code;   rise_v[CI_EN]      = W'(EN_TH);    fall_v[CI_EN]      = W'(EN_TH);
        code_v[CI_OVP]     = fb_code;   rise_v[CI_OVP]     = W'(OVP_ON);   fall_v[CI_OVP]     = W'(OVP_OFF);
        code_v[CI_FBHI]    = fb_code;   rise_v[CI_FBHI]    = W'(BOOST_TH); fall_v[CI_FBHI]    = W'(BOOST_TH);
        code_v[CI_VAOOK]   = vao_code;  rise_v[CI_VAOOK]   = W'(ZP_CLR);   fall_v[CI_VAOOK]   = W'(ZP_SET);
        code_v[CI_SSOK]    = ss_code;   rise_v[CI_SSOK]    = W'(SSDIS_TH); fall_v[CI_SSOK]    = W'(SSDIS_TH);
        code_v[CI_HOT]     = temp_code; rise_v[CI_HOT]     = W'(HOT_ON);   fall_v[CI_HOT]     = W'(HOT_OFF);
        code_v[CI_SSREACH] = ss_code;   rise_v[CI_SSREACH] = fb_code;      fall_v[CI_SSREACH] = fb_code;
        code_v[CI_SSDONE]  = ss_code;   rise_v[CI_SSDONE]  = W'(SS_REG);   fall_v[CI_SSDONE]  = W'(SS_REG);
    end

    pfc_cmp_bank #(
        .W        (W),
        .FILT_LEN (FILT_LEN)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .code_v (code_v),
        .rise_v (rise_v),
        .fall_v (fall_v),
        .lvl_v  (lvl_v)
    );

    pfc_sup_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .uvlo_ok    (lvl_v[CI_UVLO]),
        .en_ok      (lvl_v[CI_EN]),
        .ovp        (lvl_v[CI_OVP]),
        .fb_hi      (lvl_v[CI_FBHI]),
        .vao_ok     (lvl_v[CI_VAOOK]),
        .ss_ok      (lvl_v[CI_SSOK]),
        .hot        (lvl_v[CI_HOT]),
        .ss_reach   (lvl_v[CI_SSREACH]),
        .ss_done    (lvl_v[CI_SSDONE]),
        .gate_en_o  (gate_en),
        .ca_reset_o (ca_reset),
        .ss_mode_o  (ss_mode),
        .boost_en_o (boost_en)
    );

    assign ref_en = lvl_v[CI_VREF];

    AST_REF_FOLLOWS_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_v[CI_UVLO] |-> ref_en); // R4

endmodule

// File: tb/tb_pfc_startup_supervisor.sv
module tb_pfc_startup_supervisor;
    localparam int W    = 10;
    localparam int FILT = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b1;
    logic [W-1:0] vcc_code = '0, fb_code = '0, vao_code = '0, ss_code = '0, temp_code = '0;
    logic         gate_en, ca_reset, boost_en, ref_en;
    logic [1:0]   ss_mode;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit model_on = 0;

    always #2 clk = ~clk;

    pfc_startup_supervisor dut (
        .clk(clk), .rst_n(rst_n), .vcc_code(vcc_code), .fb_code(fb_code),
        .vao_code(vao_code), .ss_code(ss_code), .temp_code(temp_code),
        .gate_en(gate_en), .ca_reset(ca_reset), .ss_mode(ss_mode),
        .boost_en(boost_en), .ref_en(ref_en)
    );

    // ---------------- reference model ----------------
    int qv[$], qf[$], qa[$], qs[$], qt[$];
    bit mf[10];
    int mstate;   // 0 off,1 wait,2 holdoff,3 prechg,4 ramp,5 run
    bit m_gate, m_ca, m_boost;
    int m_mode;

    function automatic bit cmpf(int c, int r, int f, bit cur);
        if (c < 0 || r < 0 || f < 0) return 1'b0;
        return cur ? (c >= f) : (c >= r);
    endfunction

    function automatic bit evalk(int k, int i, bit cur);
        case (k)
            0: return cmpf(qv[i], 160, 160, cur);
            1: return cmpf(qv[i], 204, 184, cur);
            2: return cmpf(qf[i], 150, 150, cur);
            3: return cmpf(qf[i], 637, 616, cur);
            4: return cmpf(qf[i], 558, 558, cur);
            5: return cmpf(qa[i], 180, 150, cur);
            6: return cmpf(qs[i], 120, 120, cur);
            7: return cmpf(qt[i], 161, 140, cur);
            8: return cmpf(qs[i], qf[i], qf[i], cur);
            default: return cmpf(qs[i], 600, 600, cur);
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            qv = {}; qf = {}; qa = {}; qs = {}; qt = {};
            for (int i = 0; i < FILT + 2; i++) begin
                qv.push_back(-1); qf.push_back(-1); qa.push_back(-1);
                qs.push_back(-1); qt.push_back(-1);
            end
            foreach (mf[k]) mf[k] = 0;
            mstate = 0; m_gate = 0; m_ca = 0; m_boost = 0; m_mode = 0;
            model_on = 1;
        end else begin
            int ns;
            bit nf[10];
            qv.push_front(int'(vcc_code)); void'(qv.pop_back());
            qf.push_front(int'(fb_code));  void'(qf.pop_back());
            qa.push_front(int'(vao_code)); void'(qa.pop_back());
            qs.push_front(int'(ss_code));  void'(qs.pop_back());
            qt.push_front(int'(temp_code)); void'(qt.pop_back());
            // sequencing from the previous filtered levels
            ns = mstate;
            if (!mf[1] || mf[7]) ns = 0;
            else if (mstate == 0) ns = 1;
            else if (mstate == 1) begin if (mf[2]) ns = 2; end
            else if (!mf[2]) ns = 1;
            else if (mstate == 2 && !mf[5]) ns = 3;
            else if (mstate == 3 && mf[8]) ns = 4;
            else if (mstate == 4 && mf[9]) ns = 5;
            m_mode  = (ns == 3) ? 1 : (ns >= 4) ? 2 : 0;
            m_gate  = (ns >= 3) && mf[1] && mf[2] && !mf[3] && !mf[7] && mf[5] && mf[6];
            m_ca    = mf[3];
            m_boost = (ns == 5) && !mf[4];
            mstate  = ns;
            // filtered levels: flip after FILT consecutive opposite samples
            for (int k = 0; k < 10; k++) begin
                bit all_diff;
                all_diff = 1;
                for (int i = 2; i <= FILT + 1; i++)
                    if (evalk(k, i, mf[k]) == mf[k]) all_diff = 0;
                nf[k] = all_diff ? !mf[k] : mf[k];
            end
            mf = nf;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (model_on) begin
            bit bad;
            bad = 0;
            n_checks++;
            if (gate_en !== m_gate) begin bad = 1; $display("FAIL R12 cyc %0d gate_en act %0b exp %0b", cycles, gate_en, m_gate); end
            if (ss_mode !== 2'(m_mode)) begin bad = 1; $display("FAIL R6 cyc %0d ss_mode act %0d exp %0d", cycles, ss_mode, m_mode); end
            if (boost_en !== m_boost) begin bad = 1; $display("FAIL R11 cyc %0d boost_en act %0b exp %0b", cycles, boost_en, m_boost); end
            if (ca_reset !== m_ca) begin bad = 1; $display("FAIL R8 cyc %0d ca_reset act %0b exp %0b", cycles, ca_reset, m_ca); end
            if (ref_en !== mf[0]) begin bad = 1; $display("FAIL R4 cyc %0d ref_en act %0b exp %0b", cycles, ref_en, mf[0]); end
            if (bad) n_fail++;
        end
        if (cycles > 100000) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog act %0d exp <100000 cycles", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // ---------------- scenario checks ----------------
    task automatic expect_out(string tag, bit g, int m, bit b, bit c, bit r);
        n_checks++;
        if (gate_en !== g || ss_mode !== 2'(m) || boost_en !== b || ca_reset !== c || ref_en !== r) begin
            n_fail++;
            $display("FAIL %s act g%0b m%0d b%0b c%0b r%0b exp g%0b m%0d b%0b c%0b r%0b",
                     tag, gate_en, ss_mode, boost_en, ca_reset, ref_en, g, m, b, c, r);
        end
    endtask

    task automatic settle(int n = 16);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1 rst_n = 1'b0;
        repeat (4) @(negedge clk);
        expect_out("R1 in reset", 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1 after reset", 0, 0, 0, 0, 0);

        vcc_code = 170;  settle(); expect_out("R4 ref on", 0, 0, 0, 0, 1);
        vcc_code = 190;  settle(); expect_out("R3 below on-level", 0, 0, 0, 0, 1);
        vcc_code = 210;  settle(); expect_out("R3 uvlo released", 0, 0, 0, 0, 1);
        vao_code = 300;  fb_code = 160; settle();
        expect_out("R5 hold-off waits for zero power", 0, 0, 0, 0, 1);
        vao_code = 100;  settle(); expect_out("R5 precharge starts", 0, 1, 0, 0, 1);
        ss_code = 170;   settle(); expect_out("R6 slow ramp, R11 no boost", 0, 2, 0, 0, 1);
        vao_code = 170;  settle(); expect_out("R9 band keeps fault", 0, 2, 0, 0, 1);
        vao_code = 200;  settle(); expect_out("R9 clear, R12 gate", 1, 2, 0, 0, 1);
        ss_code = 610;   settle(); expect_out("R6 run, R11 boost", 1, 2, 1, 0, 1);
        fb_code = 600;   settle(); expect_out("R11 boost off", 1, 2, 0, 0, 1);

        temp_code = 200; repeat (2) @(negedge clk); temp_code = 0;
        settle(); expect_out("R2 glitch ignored", 1, 2, 0, 0, 1);

        ss_code = 100;   settle(); expect_out("R7 ext disable", 0, 2, 0, 0, 1);
        ss_code = 610;   settle(); expect_out("R7 resume", 1, 2, 0, 0, 1);

        fb_code = 640;   settle(); expect_out("R8 ovp trip", 0, 2, 0, 1, 1);
        fb_code = 620;   settle(); expect_out("R8 ovp band", 0, 2, 0, 1, 1);
        fb_code = 600;   settle(); expect_out("R8 ovp clear", 1, 2, 0, 0, 1);

        vao_code = 140;  settle(); expect_out("R9 zero power", 0, 2, 0, 0, 1);
        vao_code = 170;  settle(); expect_out("R9 hysteresis", 0, 2, 0, 0, 1);
        vao_code = 190;  settle(); expect_out("R9 recover", 1, 2, 0, 0, 1);

        temp_code = 170; settle(); expect_out("R10 thermal off", 0, 0, 0, 0, 1);
        temp_code = 150; settle(); expect_out("R10 thermal band", 0, 0, 0, 0, 1);
        temp_code = 100; settle(); expect_out("R10 back to hold-off", 0, 0, 0, 0, 1);
        vao_code = 100;  settle(); expect_out("R10 new soft start", 0, 2, 0, 0, 1);
        vao_code = 200;  settle(); expect_out("R12 gating again", 1, 2, 0, 0, 1);

        vcc_code = 190;  settle(); expect_out("R3 band keeps run", 1, 2, 0, 0, 1);
        vcc_code = 180;  settle(); expect_out("R3 uvlo trip", 0, 0, 0, 0, 1);
        vcc_code = 150;  settle(); expect_out("R4 ref off", 0, 0, 0, 0, 0);
        vcc_code = 210;  settle(); expect_out("R5 hold-off after restart", 0, 0, 0, 0, 1);
        fb_code = 100;   settle(); expect_out("R5 enable lost", 0, 0, 0, 0, 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule